// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Slave

This block is the slave end of a three-wire host bus: a host clock, an active-low strobe and one bidirectional data line. The host pulls the strobe low and sends a header of ten bits on rising clock edges. The header holds a direction bit, a broadcast bit and an 8-bit address. The transfer then carries a 16-bit data word, most significant bit first. On a write, the data word comes from the host. On a read, the slave drives the word onto the shared line, changing it on falling clock edges.

Behind the serial logic sits a register file of four identical channel banks, each of `NREG` 16-bit registers. A channel-select register picks the bank that reads and ordinary writes use. A broadcast write updates the same offset in all four banks at once. All logic runs on the host clock, so the host may stop that clock, held low, between transactions.

The controller is a state machine with seven states: READY, HDR, WDATA, RDATA, DONE, GUARD and LOCK. Every step below happens on a rising host-clock edge.
- READY goes to HDR when the strobe is low, and that edge captures bit 1.
- HDR goes to WDATA or RDATA after the tenth bit.
- WDATA and RDATA go to DONE after sixteen data bits.
- Any of HDR, WDATA, RDATA or DONE goes to GUARD when the strobe is seen high.
- GUARD goes to READY after its second strobe-high edge.
- GUARD goes to LOCK when the strobe falls too early.
- LOCK goes to GUARD when the strobe is high again.
- Reset places the machine in READY.

Top module: `tw_reg_slave`

## Requirements
- R1: The first bit sampled after the strobe falls selects the direction: 1 is a read and 0 is a write. Only a write changes registers.
- R2: The line is sampled on rising edges. Bits 3 to 10 are the address and bits 11 to 26 are the data, both most significant bit first. Edges after bit 26 are ignored until the strobe rises.
- R3: On a read, the slave drives the line from the falling edge after bit 10. It presents data bit 15 first, then one bit per falling edge. It releases the line as soon as the strobe is high, and it never drives during a write.
- R4: A write with broadcast bit 1 to a bank address stores the word at that offset in all four banks.
- R5: A write with broadcast bit 0 to a bank address changes only the bank named by the channel-select register.
- R6: Address 0x00 is the channel-select register. Data bits [1:0] hold the bank number, and a read returns that number zero-extended. It is also driven on `sel_ch_o`.
- R7: Address 0x10+k, for k < NREG, is bank register k. Writes to any other address (except 0x00) change nothing, and reads of them return 0.
- R8: The broadcast bit is ignored on reads. Read data always comes from the selected bank.
- R9: If the strobe rises before bit 26 of a write, no register changes.
- R10: After a transaction, the strobe must be high on at least two rising edges. A transaction started sooner is ignored entirely: no write and no drive of the line.
- R11: Stopping the host clock low between transactions loses no state.
- R12: An asynchronous active-low reset clears every register and the channel select, releases the line, and leaves the slave ready for a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host serial clock, may be stopped low |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low transaction strobe |
| data_io | inout | 1 | Shared serial data line |
| sel_ch_o | output | $clog2(NCH) | Current channel-select value |
| bank_regs_o | output | NCH*NREG*DATA_W | All bank registers, bank-major, offset within bank |

## Verification
A wrong header count or a misplaced shift shows up as an address or data error: the word read back, or the bank word on `bank_regs_o`, no longer matches what was written. This becomes visible one edge after bit 26. A wrong guard or abort state shows on the following transaction: a write lands that should have been dropped, or a read returns pulled-up ones where it should return data. A stale drive enable corrupts the next bits the host places on the shared line.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_HDR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE,
        ST_GUARD,
        ST_LOCK
    } fe_state_e;

    // Address of the channel-select register.
    localparam int unsigned SEL_ADDR  = 0;
    // Upper address nibble that selects the channel-bank page.
    localparam int unsigned BANK_PAGE = 1;
    // Width of the in-page register index field.
    localparam int unsigned IDX_W     = 4;

endpackage

// File: rtl/tw_chan_bank.sv
module tw_chan_bank #(
    parameter int unsigned NREG   = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned REG_IW = 2
) (
    input  logic                             host_clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [REG_IW-1:0]                idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NREG-1:0][DATA_W-1:0]      words_o
);

    logic [NREG-1:0][DATA_W-1:0] words_q;

    always_ff @(posedge host_clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else if (we) begin
            for (int k = 0; k < int'(NREG); k++) begin
                if (idx == REG_IW'(k)) begin
                    words_q[k] <= wdata;
                end
            end
        end
    end

    assign words_o = words_q;

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
    import tw_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned NREG   = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                                   host_clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic                                   wr_bcast,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic [ADDR_W-1:0]                      rd_addr,
    output logic [DATA_W-1:0]                      rd_data,
    output logic [$clog2(NCH)-1:0]                 sel_o,
    output logic [NCH-1:0][NREG-1:0][DATA_W-1:0]   regs_o
);

    localparam int unsigned CH_W   = $clog2(NCH);
    localparam int unsigned PAGE_W = ADDR_W - IDX_W;
    localparam int unsigned REG_IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);

    function automatic logic bank_hit(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:IDX_W] == PAGE_W'(BANK_PAGE)) &&
               (a[IDX_W-1:0] < IDX_W'(NREG));
    endfunction

    logic [CH_W-1:0]                       sel_q;
    logic [NCH-1:0]                        bank_we;
    logic [NCH-1:0][NREG-1:0][DATA_W-1:0]  all_q;
    logic                                  wr_hit;
    logic                                  rd_hit;

    assign wr_hit = bank_hit(wr_addr);
    assign rd_hit = bank_hit(rd_addr);

    always_ff @(posedge host_clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en && wr_addr == SEL_A) begin
            sel_q <= wr_data[CH_W-1:0];
        end
    end

    for (genvar g = 0; g < int'(NCH); g++) begin : g_bank
        assign bank_we[g] = wr_en && wr_hit && (wr_bcast || sel_q == CH_W'(g));

        tw_chan_bank #(
            .NREG   (NREG),
            .DATA_W (DATA_W),
            .REG_IW (REG_IW)
        ) u_bank (
            .host_clk (host_clk),
            .rst_n    (rst_n),
            .we       (bank_we[g]),
            .idx      (wr_addr[REG_IW-1:0]),
            .wdata    (wr_data),
            .words_o  (all_q[g])
        );

        // R4: a broadcast write lands in every bank at the same offset
        assert_bcast_all_R4: assert property (@(posedge host_clk) disable iff (!rst_n)
            (wr_en && wr_bcast && wr_hit) |=>
            (all_q[g][$past(wr_addr[REG_IW-1:0])] == $past(wr_data)));

        // R5: a single-channel write leaves the other banks untouched
        assert_single_bank_R5: assert property (@(posedge host_clk) disable iff (!rst_n)
            (wr_en && !wr_bcast && wr_hit && sel_q != CH_W'(g)) |=> $stable(all_q[g]));
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == SEL_A) begin
            rd_data = DATA_W'(sel_q);
        end else if (rd_hit) begin
            rd_data = all_q[sel_q][rd_addr[REG_IW-1:0]];
        end
    end

    assign sel_o  = sel_q;
    assign regs_o = all_q;

    // R7: writes outside the map change no state
    assert_unmapped_R7: assert property (@(posedge host_clk) disable iff (!rst_n)
        (wr_en && !wr_hit && wr_addr != SEL_A) |=> ($stable(all_q) && $stable(sel_q)));

endmodule

// File: rtl/tw_frontend.sv
module tw_frontend
    import tw_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned GUARD_EDGES = 2
) (
    input  logic              host_clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              din,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic              wr_bcast_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              dout_o,
    output logic              oe_o
);

    localparam int unsigned HDR_BITS = 2 + ADDR_W;
    localparam int unsigned HC_W     = $clog2(HDR_BITS + 1);
    localparam int unsigned DC_W     = $clog2(DATA_W);
    localparam int unsigned GC_W     = $clog2(GUARD_EDGES + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HDR_BITS - 1);
    localparam logic [HC_W-1:0] HC_FULL = HC_W'(HDR_BITS);
    localparam logic [DC_W-1:0] DC_LAST = DC_W'(DATA_W - 1);
    localparam logic [GC_W-1:0] GC_LAST = GC_W'(GUARD_EDGES - 1);

    fe_state_e          st_q, st_d;
    logic [HC_W-1:0]    bcnt_q;
    logic [DC_W-1:0]    dcnt_q;
    logic [GC_W-1:0]    gcnt_q;
    logic               rw_q;
    logic               bc_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wsh_q;
    logic [DATA_W-1:0]  rsh_q;
    logic               rd_active_q;
    logic               oe_q;
    logic               dout_q;

    // State register
    always_ff @(posedge host_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_READY;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY: if (!strobe_n) st_d = ST_HDR;
            ST_HDR: begin
                if (strobe_n)                st_d = ST_GUARD;
                else if (bcnt_q == HC_LAST)  st_d = rw_q ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA, ST_RDATA: begin
                if (strobe_n)                st_d = ST_GUARD;
                else if (dcnt_q == DC_LAST)  st_d = ST_DONE;
            end
            ST_DONE:  if (strobe_n) st_d = ST_GUARD;
            ST_GUARD: begin
                if (!strobe_n)               st_d = ST_LOCK;
                else if (gcnt_q == GC_LAST)  st_d = ST_READY;
            end
            ST_LOCK:  if (strobe_n) st_d = ST_GUARD;
        endcase
    end

    // Datapath and output registers on the sampling edge
    always_ff @(posedge host_clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q      <= '0;
            dcnt_q      <= '0;
            gcnt_q      <= '0;
            rw_q        <= 1'b0;
            bc_q        <= 1'b0;
            addr_q      <= '0;
            wsh_q       <= '0;
            rsh_q       <= '0;
            rd_active_q <= 1'b0;
        end else if (strobe_n) begin
            rd_active_q <= 1'b0;
            gcnt_q      <= (st_q == ST_GUARD) ? gcnt_q + 1'b1 : GC_W'(1);
        end else begin
            case (st_q)
                ST_READY: begin
                    rw_q   <= din;
                    bc_q   <= 1'b0;
                    bcnt_q <= HC_W'(1);
                end
                ST_HDR: begin
                    bcnt_q <= bcnt_q + 1'b1;
                    if (bcnt_q == HC_W'(1)) begin
                        bc_q <= din;
                    end else begin
                        addr_q <= {addr_q[ADDR_W-2:0], din};
                    end
                    if (bcnt_q == HC_LAST) begin
                        dcnt_q <= '0;
                        if (rw_q) begin
                            rsh_q       <= rd_word;
                            rd_active_q <= 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    wsh_q  <= {wsh_q[DATA_W-2:0], din};
                    dcnt_q <= dcnt_q + 1'b1;
                end
                ST_RDATA: begin
                    rsh_q  <= {rsh_q[DATA_W-2:0], 1'b0};
                    dcnt_q <= dcnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Read data and drive enable change on the falling edge
    always_ff @(negedge host_clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            oe_q   <= rd_active_q;
            dout_q <= rsh_q[DATA_W-1];
        end
    end

    assign rd_addr_o  = {addr_q[ADDR_W-2:0], din};
    assign wr_en_o    = (st_q == ST_WDATA) && !strobe_n && (dcnt_q == DC_LAST);
    assign wr_bcast_o = bc_q;
    assign wr_addr_o  = addr_q;
    assign wr_data_o  = {wsh_q[DATA_W-2:0], din};
    assign dout_o     = dout_q;
    assign oe_o       = oe_q & ~strobe_n;

    // R1: a commit only follows a full header of a write
    assert_write_after_header_R1: assert property (@(posedge host_clk) disable iff (!rst_n)
        wr_en_o |-> (!rw_q && bcnt_q == HC_FULL));

    // R3: the line is only driven inside a read
    assert_drive_only_read_R3: assert property (@(posedge host_clk) disable iff (!rst_n)
        (oe_q && !strobe_n) |-> rw_q);

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
    parameter int unsigned NCH         = 4,
    parameter int unsigned NREG        = 4,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned GUARD_EDGES = 2
) (
    input  logic                          host_clk,
    input  logic                          rst_n,
    input  logic                          strobe_n,
    inout  wire                           data_io,
    output logic [$clog2(NCH)-1:0]        sel_ch_o,
    output logic [NCH*NREG*DATA_W-1:0]    bank_regs_o
);

    logic                                  din;
    logic                                  dout;
    logic                                  oe;
    logic                                  wr_en;
    logic                                  wr_bcast;
    logic [ADDR_W-1:0]                     wr_addr;
    logic [DATA_W-1:0]                     wr_data;
    logic [ADDR_W-1:0]                     rd_addr;
    logic [DATA_W-1:0]                     rd_data;
    logic [NCH-1:0][NREG-1:0][DATA_W-1:0]  regs;

    assign din     = data_io;
    assign data_io = oe ? dout : 1'bz;

    tw_frontend #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .GUARD_EDGES (GUARD_EDGES)
    ) u_fe (
        .host_clk   (host_clk),
        .rst_n      (rst_n),
        .strobe_n   (strobe_n),
        .din        (din),
        .rd_word    (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_en_o    (wr_en),
        .wr_bcast_o (wr_bcast),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .dout_o     (dout),
        .oe_o       (oe)
    );

    tw_regfile #(
        .NCH    (NCH),
        .NREG   (NREG),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rf (
        .host_clk (host_clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bcast (wr_bcast),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sel_o    (sel_ch_o),
        .regs_o   (regs)
    );

    assign bank_regs_o = regs;

endmodule

// File: tb/tb_tw_reg_slave.sv
module tb_tw_reg_slave;

    localparam int NCH  = 4;
    localparam int NREG = 4;
    localparam int DW   = 16;

    logic clk      = 1'b0;
    logic clk_run  = 1'b1;
    logic rst_n    = 1'b0;
    logic strobe_n = 1'b1;
    logic tb_oe    = 1'b0;
    logic tb_bit   = 1'b0;
    wire  host_clk = clk & clk_run;
    wire  data_io;
    logic [1:0]             sel_ch;
    logic [NCH*NREG*DW-1:0] bank_regs;
    int checks = 0;
    int errors = 0;

    pullup (data_io);
    assign data_io = tb_oe ? tb_bit : 1'bz;

    always #10 clk = ~clk;

    tw_reg_slave dut (
        .host_clk    (host_clk),
        .rst_n       (rst_n),
        .strobe_n    (strobe_n),
        .data_io     (data_io),
        .sel_ch_o    (sel_ch),
        .bank_regs_o (bank_regs)
    );

    function automatic logic [15:0] bw(input int ch, input int k);
        return bank_regs[(ch*NREG+k)*DW +: DW];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One transaction: nbits edges with strobe low, then gap extra strobe-high edges
    task automatic xfer(input logic rw, input logic bc, input logic [7:0] addr,
                        input logic [15:0] wd, input int nbits, input int gap,
                        output logic [15:0] rd);
        logic [9:0] hdr;
        hdr = {rw, bc, addr};
        rd  = '0;
        for (int i = 1; i <= nbits; i++) begin
            @(negedge clk);
            strobe_n = 1'b0;
            if (i <= 10) begin
                tb_oe  = 1'b1;
                tb_bit = hdr[10-i];
            end else if (!rw) begin
                tb_oe  = 1'b1;
                tb_bit = wd[26-i];
            end else begin
                tb_oe = 1'b0;
                #5;
                rd[26-i] = data_io;
            end
        end
        @(negedge clk);
        strobe_n = 1'b1;
        tb_oe    = 1'b0;
        for (int j = 0; j < gap; j++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic bc);
        logic [15:0] dummy;
        xfer(1'b0, bc, a, d, 26, 1, dummy);
    endtask

    task automatic rdw(input logic [7:0] a, input logic bc, output logic [15:0] d);
        xfer(1'b1, bc, a, 16'h0, 26, 1, d);
    endtask

    task automatic t_reset;
        chk("R12", "sel after reset", 32'(sel_ch), 32'd0);
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < NREG; k++)
                chk("R12", "bank word after reset", 32'(bw(c, k)), 32'd0);
        chk("R12", "line released after reset", 32'(data_io), 32'd1);
    endtask

    task automatic t_select_single;
        logic [15:0] d;
        wr(8'h00, 16'h0002, 1'b0);
        chk("R6", "sel port", 32'(sel_ch), 32'd2);
        rdw(8'h00, 1'b0, d);
        chk("R6", "sel readback", 32'(d), 32'd2);
        wr(8'h11, 16'hA5C3, 1'b0);
        chk("R5", "ch2 off1 written", 32'(bw(2, 1)), 32'hA5C3);
        chk("R5", "ch0 off1 untouched", 32'(bw(0, 1)), 32'h0);
        chk("R5", "ch3 off1 untouched", 32'(bw(3, 1)), 32'h0);
        rdw(8'h11, 1'b0, d);
        chk("R2", "read back MSB-first word", 32'(d), 32'hA5C3);
        chk("R3", "line released after read", 32'(data_io), 32'd1);
    endtask

    task automatic t_broadcast;
        logic [15:0] d;
        wr(8'h13, 16'h1234, 1'b1);
        for (int c = 0; c < NCH; c++)
            chk("R4", "broadcast word in bank", 32'(bw(c, 3)), 32'h1234);
        wr(8'h00, 16'h0000, 1'b0);
        rdw(8'h13, 1'b0, d);
        chk("R4", "broadcast readback ch0", 32'(d), 32'h1234);
    endtask

    task automatic t_read_bcast_ignored;
        logic [15:0] d;
        wr(8'h00, 16'h0001, 1'b0);
        wr(8'h10, 16'h0F0F, 1'b0);
        rdw(8'h10, 1'b1, d);
        chk("R8", "bcast read from sel bank", 32'(d), 32'h0F0F);
        wr(8'h00, 16'h0003, 1'b0);
        rdw(8'h10, 1'b1, d);
        chk("R8", "bcast read ch3 empty", 32'(d), 32'h0);
        chk("R1", "read changed nothing", 32'(bw(1, 0)), 32'h0F0F);
    endtask

    task automatic t_unmapped;
        logic [NCH*NREG*DW-1:0] snap;
        logic [15:0] d;
        snap = bank_regs;
        wr(8'h25, 16'hFFFF, 1'b0);
        wr(8'h14, 16'hFFFF, 1'b1);
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < NREG; k++)
                chk("R7", "unmapped write no effect", 32'(bw(c, k)),
                    32'(snap[(c*NREG+k)*DW +: DW]));
        chk("R7", "sel kept", 32'(sel_ch), 32'd3);
        rdw(8'h25, 1'b0, d);
        chk("R7", "unmapped read zero", 32'(d), 32'h0);
        rdw(8'h14, 1'b0, d);
        chk("R7", "out-of-range read zero", 32'(d), 32'h0);
    endtask

    task automatic t_abort;
        logic [15:0] d;
        wr(8'h00, 16'h0000, 1'b0);
        wr(8'h12, 16'h00F0, 1'b0);
        xfer(1'b0, 1'b0, 8'h12, 16'hBEEF, 20, 1, d);
        chk("R9", "aborted write dropped", 32'(bw(0, 2)), 32'h00F0);
        xfer(1'b0, 1'b1, 8'h12, 16'hBEEF, 25, 1, d);
        rdw(8'h12, 1'b0, d);
        chk("R9", "abort at bit 25 dropped", 32'(d), 32'h00F0);
    endtask

    task automatic t_guard;
        logic [15:0] d;
        xfer(1'b1, 1'b0, 8'h12, 16'h0, 26, 0, d);
        chk("R3", "read before short gap", 32'(d), 32'h00F0);
        xfer(1'b0, 1'b0, 8'h12, 16'h5555, 26, 1, d);
        chk("R10", "early write ignored", 32'(bw(0, 2)), 32'h00F0);
        xfer(1'b1, 1'b0, 8'h12, 16'h0, 26, 0, d);
        chk("R10", "read after full gap", 32'(d), 32'h00F0);
        xfer(1'b1, 1'b0, 8'h12, 16'h0, 26, 1, d);
        chk("R10", "early read not driven", 32'(d), 32'hFFFF);
        rdw(8'h12, 1'b0, d);
        chk("R10", "recovered after lockout", 32'(d), 32'h00F0);
    endtask

    task automatic t_clock_stop;
        logic [15:0] d;
        wr(8'h10, 16'h3C69, 1'b0);
        @(negedge clk);
        clk_run = 1'b0;
        repeat (25) @(negedge clk);
        chk("R11", "held while clock stopped", 32'(bw(0, 0)), 32'h3C69);
        clk_run = 1'b1;
        rdw(8'h10, 1'b0, d);
        chk("R11", "readback after clock stop", 32'(d), 32'h3C69);
    endtask

    task automatic t_midreset;
        logic [15:0] d;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R12", "mid reset sel", 32'(sel_ch), 32'd0);
        chk("R12", "mid reset bank", 32'(bw(0, 0)), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rdw(8'h13, 1'b0, d);
        chk("R12", "ready after reset, reg zero", 32'(d), 32'h0);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select_single();
        t_broadcast();
        t_read_bcast_ignored();
        t_unmapped();
        t_abort();
        t_guard();
        t_clock_stop();
        t_midreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule